// File: doc/BRIEF.md
# Serial Receive Channel with Word-Locked Status

This block is the receive half of an asynchronous serial port. A 16x oversampling enable paces it. It watches the serial input for a falling edge and confirms the start bit at its midpoint. It then recovers between five and eight data bits, least significant first, plus an optional parity bit and one stop bit. Each finished character moves into a single holding register. At the same moment the block captures a status snapshot of that character's own error flags.

The CPU reaches the block through a small register port with three registers: control, status and data. The status snapshot stays frozen until the CPU reads the data register, so the flags always describe the word sitting beside them. A character that arrives while the holding register is still occupied is dropped. The loss is reported in the snapshot of the next character that is accepted.

The register port is a plain strobe interface with no valid/ready handshake. The full flag and the interrupt level carry the flow control. The sender cannot be stalled, so the only back-pressure is the rule that an unread word is never overwritten.

Top module: `uart_rx_latched`

## Requirements
- R1: After reset, the data register reads 0x00, the status register reads 0x00, the control register reads 0x18, address 3 reads 0x00 and `irq` is low.
- R2: Control bits [4:3] select the character length as 5 plus their value. Data bits arrive least significant first and are right-justified in the data register, with the unused upper bits reading zero.
- R3: A completed character that finds the holding register empty is stored, and status bit 7 (full) becomes 1.
- R4: `irq` is high exactly while the full bit is set and control bit 5 (interrupt enable) is 1. It is low in the cycle after a data register read.
- R5: A read strobe at address 2 (data) clears the full bit. A read at address 1 (status) leaves it set.
- R6: While the full bit is set, the data register and the status flags in bits [6:4] do not change.
- R7: A character that completes while the holding register is full is discarded. The next stored character's snapshot has bit 6 (overrun) set, and the snapshot after that has it cleared.
- R8: With control bit 2 (parity enable) at 1, one parity bit follows the data. Control bit 1 selects even parity when 1 and odd parity when 0. A mismatch sets status bit 5.
- R9: With parity disabled, the stop bit directly follows the data bits, and status bit 5 is 0.
- R10: A stop bit sampled low sets status bit 4 (framing error) for that character.
- R11: A low pulse that is high again at the start bit's midpoint is rejected and stores no character.
- R12: Control writes keep only bits [5:1]. Bit 0 and bits [7:6] always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_rd | input | 1 | Read strobe; a read of address 2 consumes the word |
| reg_wr | input | 1 | Write strobe; only the control register is writable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Receive interrupt level |

## Verification
A wrong bit counter or a wrong sample phase shows up in the data register on the very character where it occurs, as shifted or misplaced bits. For that reason every length is swept across many data patterns. A full flag that clears at the wrong time, or a status snapshot that is not held, shows up in the status read that follows the second character sent without an intervening data read. A lost overrun record shows up in the snapshot of the next accepted word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  typedef struct packed {
    logic ovr;
    logic perr;
    logic ferr;
  } rx_flags_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  localparam int CW    = $clog2(OSR),
  localparam int BW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [BW-1:0]     len_m1,
  input  logic              par_en,
  input  logic              par_even,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t         st;
  logic              rx_m, rx_s, prev, pbit;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      prev <= 1'b1;
      pbit <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= rx_s;
        case (st)
          S_IDLE: if (prev && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt <= '0;
            if (rx_s) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              bitn <= '0;
              sh   <= '0;
            end
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == LAST) begin
            cnt      <= '0;
            sh[bitn] <= rx_s;
            if (bitn == len_m1) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == LAST) begin
            cnt  <= '0;
            pbit <= rx_s;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == LAST) begin
            cnt  <= '0;
            st   <= S_IDLE;
            done <= 1'b1;
            data <= sh;
            ferr <= !rx_s;
            perr <= par_en & ((^sh) ^ pbit ^ !par_even);
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11: a start bit that is high at its midpoint sends the receiver back to idle
  p_noise_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == MID && rx_s) |=> (st == S_IDLE));

  // R2: the bits above the configured length are zero
  p_justify_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((data >> ({1'b0, len_m1} + 1'b1)) == '0));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q,
  output rx_flags_t         flags_q
);
  logic ovr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      ovr_pend <= 1'b0;
      data_q   <= '0;
      flags_q  <= '0;
    end else if (full) begin
      if (take) full <= 1'b0;
      if (done) ovr_pend <= 1'b1;
    end else if (done) begin
      data_q   <= din;
      flags_q  <= '{ovr: ovr_pend, perr: perr_in, ferr: ferr_in};
      full     <= 1'b1;
      ovr_pend <= 1'b0;
    end
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && done) |=> full);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take) |=> !full);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data_q) && $stable(flags_q)));

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && done) |=> ovr_pend);
endmodule

// File: rtl/uart_rx_latched.sv
module uart_rx_latched
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int          BW        = $clog2(DATA_W);
  localparam logic [7:0]  CTRL_MASK = 8'h3E;
  localparam logic [7:0]  CTRL_RST  = 8'h18;

  logic [7:0]        ctrl_q;
  logic              done, perr, ferr, full, take;
  logic [DATA_W-1:0] s_data, b_data;
  logic [BW-1:0]     len_m1;
  rx_flags_t         flags;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
  end

  assign len_m1 = BW'(4 + int'(ctrl_q[4:3]));
  assign take   = reg_rd && (reg_addr == ADDR_DATA);
  assign irq    = full && ctrl_q[5];

  uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .len_m1(len_m1), .par_en(ctrl_q[2]), .par_even(ctrl_q[1]),
    .done(done), .data(s_data), .perr(perr), .ferr(ferr));

  uart_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk(clk), .rst_n(rst_n), .done(done), .din(s_data),
    .perr_in(perr), .ferr_in(ferr), .take(take),
    .full(full), .data_q(b_data), .flags_q(flags));

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = {full, flags.ovr, flags.perr, flags.ferr, 4'b0};
      ADDR_DATA: reg_rdata = 8'(b_data);
      default:   reg_rdata = 8'h00;
    endcase
  end

  // R4: the interrupt is gone the cycle after the word is consumed
  p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq);

  // R12: the reserved control bit stays zero
  p_ctrl_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] == 1'b0);
endmodule

// File: tb/test_uart_rx_latched.sv
module test_uart_rx_latched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_latched i_uart_rx_latched (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    reg_addr  = 2'd0;
    reg_wdata = v;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(int len, bit pen, bit even, bit ie);
    return {2'b00, ie, 2'(len - 5), pen, even, 1'b0};
  endfunction

  task automatic bit_out(input logic b);
    @(negedge clk);
    rxd = b;
    repeat (15) @(negedge clk);
  endtask

  task automatic send(input int len, input int d, input bit pen, input bit pbit, input bit stopv);
    bit_out(1'b0);
    for (int i = 0; i < len; i++) bit_out(d[i]);
    if (pen) bit_out(pbit);
    bit_out(stopv);
    @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    tick16 = 1'b1;

    // R1: reset values
    rd_reg(2'd0, v); check("R1 ctrl", v, 8'h18);
    rd_reg(2'd1, v); check("R1 status", v, 8'h00);
    rd_reg(2'd2, v); check("R1 data", v, 8'h00);
    rd_reg(2'd3, v); check("R1 addr3", v, 8'h00);
    check("R1 irq", irq, 0);

    // R12: only bits [5:1] stored
    wr_ctrl(8'hFF);
    rd_reg(2'd0, v); check("R12 ctrl mask", v, 8'h3E);

    // R2 R3 R8 R9: sweep lengths, patterns and parity modes
    for (int len = 5; len <= 8; len++) begin
      for (int d = 0; d < (1 << len); d += 3) begin
        int  mode = d % 4;
        bit  pen  = (mode != 0);
        bit  even = (mode == 1) || (mode == 3);
        bit  good = even ? ^d[7:0] : ~^d[7:0];
        bit  pb   = (mode == 3) ? ~good : good;
        wr_ctrl(ctrl(len, pen, even, 1'b0));
        send(len, d, pen, pb, 1'b1);
        rd_reg(2'd1, v);
        check(mode == 0 ? "R9 status" : "R8 status", v, (mode == 3) ? 8'hA0 : 8'h80);
        rd_reg(2'd2, v);
        check("R2 data", v, d);
        rd_reg(2'd1, v);
        check("R5 full clear", v[7], 0);
      end
    end

    // R4: interrupt level
    wr_ctrl(ctrl(8, 0, 0, 1));
    send(8, 8'h5A, 0, 0, 1);
    check("R4 irq high", irq, 1);
    rd_reg(2'd1, v);
    check("R5 status read keeps full", v[7], 1);
    check("R4 irq after status read", irq, 1);
    rd_reg(2'd2, v);
    check("R4 irq low", irq, 0);
    wr_ctrl(ctrl(8, 0, 0, 0));
    send(8, 8'h11, 0, 0, 1);
    check("R4 irq disabled", irq, 0);
    rd_reg(2'd2, v);

    // R6 R7: overrun with frozen status
    wr_ctrl(ctrl(8, 1, 1, 0));
    send(8, 8'h3C, 1, 1'b0, 1);
    send(8, 8'hC3, 1, 1'b1, 0);
    rd_reg(2'd1, v); check("R6 status frozen", v, 8'h80);
    rd_reg(2'd2, v); check("R7 first word kept", v, 8'h3C);
    send(8, 8'h81, 1, 1'b0, 1);
    rd_reg(2'd1, v); check("R7 overrun flag", v, 8'hC0);
    rd_reg(2'd2, v); check("R7 next data", v, 8'h81);
    send(8, 8'h42, 1, 1'b0, 1);
    rd_reg(2'd1, v); check("R7 overrun cleared", v, 8'h80);
    rd_reg(2'd2, v);

    // R10: framing error
    wr_ctrl(ctrl(7, 0, 0, 0));
    send(7, 7'h55, 0, 0, 0);
    rd_reg(2'd1, v); check("R10 framing", v, 8'h90);
    rd_reg(2'd2, v); check("R10 data", v, 8'h55);

    // R11: glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    rd_reg(2'd1, v); check("R11 no word", v[7], 0);
    send(7, 7'h2B, 0, 0, 1);
    rd_reg(2'd1, v); check("R11 recovers status", v, 8'h80);
    rd_reg(2'd2, v); check("R11 recovers data", v, 8'h2B);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule